// File: doc/BRIEF.md
# Multiphase Time-over-Threshold Converter

This block measures how long a discriminator pulse stays high. Four counting clocks run at 400 MHz, each shifted by a quarter period from the next (0, 90, 180 and 270 degrees). All four come from a 200 MHz reference that is generated outside the block. Each phase has its own counter. That counter restarts when the pulse rises and advances on every edge of its phase while the pulse stays high. Adding the four counts gives a code whose least significant bit is 0.625 ns. This is four times finer than any single counting clock, and it needs no delay line.

When the pulse falls, each phase freezes its count and flips a request line. The system clock domain synchronizes these request lines and waits a short settling window. It then adds the counts of every phase that took part in the pulse and clamps the sum to the measurable range of 0 to 255 ns, which is 408 codes. The result goes to a single-entry output register with a valid/ready handshake. A result stays on the outputs, unchanged, until the consumer accepts it. A conversion that finishes while the register is still full is discarded. The producer side never stalls, because the pulse cannot be held back.

Top module: `tot_tdc`

## Requirements
- R1: While reset is asserted, and until the first conversion completes, `res_valid`, `res_code` and `res_ovf` are all 0.
- R2: For a pulse width W with 0 < W <= 255 ns, the reported code is within 1 of W / 0.625 ns. One code step is 0.625 ns and `res_ovf` is 0.
- R3: A pulse shorter than 0.625 ns that covers exactly one phase edge reports code 0 or 1.
- R4: When the summed count exceeds 408, the code is 4095 (all ones) and `res_ovf` is 1. A count of 408 or less gives `res_ovf` = 0 and a code no greater than 408.
- R5: Every pulse produces exactly one result. Without a pulse, `res_valid` stays 0.
- R6: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_code` and `res_ovf` do not change.
- R7: A conversion that completes while an earlier result is still waiting is dropped. The waiting result is not replaced, and no extra result follows.
- R8: In the clock cycle after a handshake (`res_valid` and `res_ready` both 1), `res_valid` is 0 unless a new conversion completes in that same cycle.
- R9: Counts restart on each rising edge of the pulse. A short pulse that follows a long one reports only its own width, provided the two are at least 100 ns apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the collection logic and the result interface |
| rst_n | input | 1 | Active-low asynchronous reset for all domains |
| ph_clk | input | N_PH (4) | Counting clocks at 400 MHz; bit k lags bit 0 by k quarter periods |
| tot_pulse | input | 1 | Asynchronous time-over-threshold pulse from the discriminator |
| res_ready | input | 1 | Consumer is ready to take the result |
| res_valid | output | 1 | A result is being presented |
| res_code | output | 12 | Pulse width in units of 0.625 ns, clamped to 4095 when out of range |
| res_ovf | output | 1 | The pulse was longer than the measurable range |

## Verification
The bench builds the block with its default values: four phases, a 408-code range, two synchronizer stages and a four-cycle settling window. With these values, a 255 ns pulse lands exactly on the last in-range code and a 256 ns pulse is the first to overflow. The 400 MHz phase clocks are offset against a 250 MHz system clock, so pulse edges fall between phase edges. The bench also uses a sub-quarter-period pulse that covers exactly one phase edge. Together these reach the single-count case, the exact range boundary, back-pressure while a second conversion finishes, and counter restart after a long pulse.

// File: rtl/tdc_pkg.sv
`timescale 1ns/1ps
package tdc_pkg;
  localparam int unsigned TDC_RES_W = 12;

  typedef struct packed {
    logic                 ovf;
    logic [TDC_RES_W-1:0] code;
  } tdc_res_t;
endpackage

// File: rtl/tdc_sync.sv
`timescale 1ns/1ps
module tdc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else        sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/tdc_phase_cnt.sv
`timescale 1ns/1ps
module tdc_phase_cnt #(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pulse_async,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tgl_o
);
  logic ps, ps_d;

  tdc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pulse_async), .q(ps)
  );

  // Restart on the rising edge, count while high, saturate at the top,
  // freeze once low, flip the request line on the falling edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_d  <= 1'b0;
      cnt_o <= '0;
      tgl_o <= 1'b0;
    end else begin
      ps_d <= ps;
      if (ps && !ps_d)                cnt_o <= CNT_W'(1);
      else if (ps && (cnt_o != '1))   cnt_o <= cnt_o + CNT_W'(1);
      if (!ps && ps_d)                tgl_o <= ~tgl_o;
    end
  end

  // R9: the count is frozen whenever the synchronized pulse is low
  a_r9_frozen_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ps |=> $stable(cnt_o));

  // R5: the request line only flips after the pulse has ended
  a_r5_request_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ps |=> $stable(tgl_o));
endmodule

// File: rtl/tdc_collect.sv
`timescale 1ns/1ps
module tdc_collect
  import tdc_pkg::*;
#(
  parameter int unsigned N_PH        = 4,
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE      = 4,
  parameter int unsigned RANGE_CODES = 408
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_PH-1:0][CNT_W-1:0] cnt_i,
  input  logic [N_PH-1:0]            tgl_i,
  output logic                       evt_valid,
  output tdc_res_t                   evt
);
  localparam int unsigned SUM_W = CNT_W + $clog2(N_PH);
  localparam int unsigned TW    = $clog2(SETTLE + 1);

  logic [N_PH-1:0]  tgl_s, seen, fresh;
  logic [SUM_W-1:0] sum;
  logic             busy;
  logic [TW-1:0]    timer;

  for (genvar g = 0; g < N_PH; g++) begin : g_req_sync
    tdc_sync #(.STAGES(SYNC_STAGES)) u_req (
      .clk(clk), .rst_n(rst_n), .d(tgl_i[g]), .q(tgl_s[g])
    );
  end

  assign fresh = tgl_s ^ seen;

  // Only phases that reported a falling edge contribute; a phase that
  // never saw a narrow pulse adds nothing.
  always_comb begin
    sum = '0;
    for (int i = 0; i < N_PH; i++)
      if (fresh[i]) sum = sum + SUM_W'(cnt_i[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= '0;
      busy      <= 1'b0;
      timer     <= '0;
      evt_valid <= 1'b0;
      evt       <= '0;
    end else begin
      evt_valid <= 1'b0;
      if (!busy) begin
        if (|fresh) begin
          busy  <= 1'b1;
          timer <= TW'(SETTLE - 1);
        end
      end else if (timer != '0) begin
        timer <= timer - TW'(1);
      end else begin
        busy      <= 1'b0;
        seen      <= tgl_s;
        evt_valid <= 1'b1;
        if (sum > SUM_W'(RANGE_CODES)) begin
          evt.ovf  <= 1'b1;
          evt.code <= '1;
        end else begin
          evt.ovf  <= 1'b0;
          evt.code <= TDC_RES_W'(sum);
        end
      end
    end
  end

  // R4: an out-of-range result carries the all-ones code
  a_r4_saturated_code: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt.ovf) |-> (evt.code == '1));

  // R4: an in-range result never exceeds the range
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt.ovf) |-> (evt.code <= TDC_RES_W'(RANGE_CODES)));
endmodule

// File: rtl/tdc_out_slot.sv
`timescale 1ns/1ps
module tdc_out_slot
  import tdc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     in_valid,
  input  tdc_res_t in_res,
  output logic     out_valid,
  input  logic     out_ready,
  output tdc_res_t out_res
);
  // Load when empty or being drained; otherwise a new result is dropped.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_res   <= '0;
    end else if (in_valid && (!out_valid || out_ready)) begin
      out_valid <= 1'b1;
      out_res   <= in_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6: a stalled result is held unchanged
  a_r6_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_res)));

  // R8: an accepted result is withdrawn when nothing new arrives
  a_r8_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/tot_tdc.sv
`timescale 1ns/1ps
module tot_tdc
  import tdc_pkg::*;
#(
  parameter int unsigned N_PH        = 4,
  parameter int unsigned RANGE_CODES = 408,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE      = 4
) (
  input  logic                 sys_clk,
  input  logic                 rst_n,
  input  logic [N_PH-1:0]      ph_clk,
  input  logic                 tot_pulse,
  input  logic                 res_ready,
  output logic                 res_valid,
  output logic [TDC_RES_W-1:0] res_code,
  output logic                 res_ovf
);
  // Per-phase headroom: one extra bit beyond the in-range share, so the
  // sum still crosses the range before any counter saturates.
  localparam int unsigned CNT_W = $clog2(RANGE_CODES / N_PH + 2) + 1;

  logic [N_PH-1:0][CNT_W-1:0] cnt;
  logic [N_PH-1:0]            tgl;
  logic                       evt_valid;
  tdc_res_t                   evt, slot_res;

  for (genvar g = 0; g < N_PH; g++) begin : g_phase
    tdc_phase_cnt #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ph (
      .clk(ph_clk[g]), .rst_n(rst_n), .pulse_async(tot_pulse),
      .cnt_o(cnt[g]), .tgl_o(tgl[g])
    );
  end

  tdc_collect #(
    .N_PH(N_PH), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES),
    .SETTLE(SETTLE), .RANGE_CODES(RANGE_CODES)
  ) u_collect (
    .clk(sys_clk), .rst_n(rst_n), .cnt_i(cnt), .tgl_i(tgl),
    .evt_valid(evt_valid), .evt(evt)
  );

  tdc_out_slot u_slot (
    .clk(sys_clk), .rst_n(rst_n), .in_valid(evt_valid), .in_res(evt),
    .out_valid(res_valid), .out_ready(res_ready), .out_res(slot_res)
  );

  assign res_code = slot_res.code;
  assign res_ovf  = slot_res.ovf;
endmodule

// File: tb/tot_tdc_tb.sv
`timescale 1ns/1ps
module tot_tdc_tb;
  logic        sys_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ph_clk = 4'b0000;
  logic        tot_pulse = 1'b0;
  logic        res_ready = 1'b1;
  logic        res_valid;
  logic [11:0] res_code;
  logic        res_ovf;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  tot_tdc u_dut (
    .sys_clk(sys_clk), .rst_n(rst_n), .ph_clk(ph_clk), .tot_pulse(tot_pulse),
    .res_ready(res_ready), .res_valid(res_valid), .res_code(res_code),
    .res_ovf(res_ovf)
  );

  always #2 sys_clk = ~sys_clk;  // 250 MHz
  initial begin            forever #1.25 ph_clk[0] = ~ph_clk[0]; end
  initial begin #0.625;    forever #1.25 ph_clk[1] = ~ph_clk[1]; end
  initial begin #1.25;     forever #1.25 ph_clk[2] = ~ph_clk[2]; end
  initial begin #1.875;    forever #1.25 ph_clk[3] = ~ph_clk[3]; end

  // Stimulus width (ps) with expected code and overflow flag
  localparam int NV = 9;
  localparam int W_PS [NV]     = '{5000, 7000, 10000, 400, 37500, 100000, 255000, 256000, 300000};
  localparam int EXP_CODE [NV] = '{8, 11, 16, 0, 60, 160, 408, 4095, 4095};
  localparam bit EXP_OVF [NV]  = '{0, 0, 0, 0, 0, 0, 0, 1, 1};

  task automatic send_pulse(input int w_ps);
    @(posedge sys_clk);
    #0.3;
    tot_pulse = 1'b1;
    #(w_ps / 1000.0);
    tot_pulse = 1'b0;
  endtask

  task automatic get_result(output bit got, output logic [11:0] c, output logic o);
    got = 0; c = '0; o = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge sys_clk);
      if (res_valid) begin
        got = 1; c = res_code; o = res_ovf;
        break;
      end
    end
  endtask

  task automatic check_code(input string req, input bit got, input logic [11:0] c,
                            input logic o, input int exp_c, input bit exp_o);
    int d;
    n_tests++;
    d = int'(c) - exp_c;
    if (!got) begin
      n_fail++;
      $display("FAIL %s: no result, actual valid=0 expected valid=1 code=%0d", req, exp_c);
    end else if (exp_o ? (o !== 1'b1 || c !== 12'hFFF) : (o !== 1'b0 || d < -1 || d > 1)) begin
      n_fail++;
      $display("FAIL %s: actual code=%0d ovf=%0b expected code=%0d ovf=%0b", req, c, o, exp_c, exp_o);
    end
  endtask

  task automatic expect_quiet(input string req, input int cycles);
    bit seen = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge sys_clk);
      if (res_valid) seen = 1;
    end
    n_tests++;
    if (seen) begin
      n_fail++;
      $display("FAIL %s: actual unexpected res_valid=1 expected 0", req);
    end
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual run still busy expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit          got;
    logic [11:0] c, held;
    logic        o;
    bit          bad;

    // R1: reset state
    repeat (5) @(negedge sys_clk);
    n_tests++;
    if (res_valid !== 1'b0 || res_code !== 12'd0 || res_ovf !== 1'b0) begin
      n_fail++;
      $display("FAIL R1: actual valid=%0b code=%0d ovf=%0b expected 0 0 0", res_valid, res_code, res_ovf);
    end
    rst_n = 1'b1;
    // R5, R1: nothing appears without a pulse
    expect_quiet("R5", 20);

    // Table walk: R2 widths, R3 narrow pulse, R4 range boundary and overflow
    for (int i = 0; i < NV; i++) begin
      send_pulse(W_PS[i]);
      get_result(got, c, o);
      if (EXP_OVF[i])          check_code("R4", got, c, o, EXP_CODE[i], EXP_OVF[i]);
      else if (W_PS[i] < 625)  check_code("R3", got, c, o, EXP_CODE[i], EXP_OVF[i]);
      else                     check_code("R2", got, c, o, EXP_CODE[i], EXP_OVF[i]);
      repeat (25) @(posedge sys_clk);
    end
    // R5: exactly one result per pulse
    expect_quiet("R5", 40);

    // R6: back-pressure holds the result
    res_ready = 1'b0;
    send_pulse(10000);
    get_result(got, held, o);
    check_code("R6", got, held, o, 16, 1'b0);
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge sys_clk);
      if (res_valid !== 1'b1 || res_code !== held) bad = 1;
    end
    n_tests++;
    if (bad) begin
      n_fail++;
      $display("FAIL R6: actual valid=%0b code=%0d expected valid=1 code=%0d", res_valid, res_code, held);
    end

    // R7: a second conversion while full is dropped
    send_pulse(20000);
    repeat (60) @(negedge sys_clk);
    n_tests++;
    if (res_valid !== 1'b1 || res_code !== held) begin
      n_fail++;
      $display("FAIL R7: actual valid=%0b code=%0d expected valid=1 code=%0d", res_valid, res_code, held);
    end

    // R8: handshake then release
    res_ready = 1'b1;
    @(negedge sys_clk);
    n_tests++;
    if (res_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: actual valid=%0b expected 0", res_valid);
    end
    // R7: dropped conversion never shows up
    expect_quiet("R7", 60);

    // R9: long pulse followed by a short one
    send_pulse(300000);
    get_result(got, c, o);
    check_code("R9", got, c, o, 4095, 1'b1);
    repeat (25) @(posedge sys_clk);
    send_pulse(5000);
    get_result(got, c, o);
    check_code("R9", got, c, o, 8, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule